// File: doc/BRIEF.md
# Interval Timer with Overflow Flag

This block is a free-running interval timer on a simple byte-wide register bus. A 12-bit prescaler runs on the system clock all the time. One of four division ratios gives a one-cycle tick. Each tick advances an 8-bit up-counter. A software-chosen counter bit defines the interval: each time that bit falls from 1 to 0 on a tick, the block sets a sticky interrupt flag and raises a one-cycle interrupt request.

Software sees two byte registers. The counter register is read-only. The control register holds four things: the prescaler choice, the overflow-bit choice, a self-clearing counter-clear bit and the interrupt flag. The flag is cleared in one of two ways: software writes 0 to it, or the interrupt controller pulses the acknowledge input. If a new overflow lands in the same cycle as either clear, the overflow wins and no interrupt is lost.

Top module: `interval_tick_timer`

## Requirements
- R1: After reset the counter register reads 0x00, the control register reads 0x01, and `irq_o` and `flag_o` are both 0.
- R2: The control register is at address 0x8B and the counter register at 0x8C. The counter register ignores writes. Every other address reads 0x00.
- R3: Control bits 6:5 choose the system-clock cycles per counter step: 00 gives 4096, 01 gives 1024, 10 gives 128 and 11 gives 16.
- R4: Control bits 2:0 hold a value n. Successive overflow events are then spaced 2^(n+1) counter steps apart. The reset value of n is 1.
- R5: With no clear pending, the counter rises by exactly one per counter step and wraps from 0xFF to 0x00.
- R6: Writing 1 to control bit 3 forces the counter to 0 at that clock edge, and counting then resumes upward. Bit 3 reads 1 in the cycle after the write and 0 from the following cycle on.
- R7: An overflow event sets control bit 7, which also appears on `flag_o`. In the same cycle `irq_o` is 1, and `irq_o` is 1 for that cycle only.
- R8: A control write with bit 7 = 0 clears the flag. A control write with bit 7 = 1 leaves the flag unchanged.
- R9: A one-cycle pulse on `int_ack` clears the flag.
- R10: If an overflow event falls in the same cycle as an acknowledge or a flag-clearing write, the flag ends up 1.
- R11: Control bit 4 always reads 0, and writing it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| int_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| irq_o | output | 1 | One-cycle interrupt request on each overflow |
| flag_o | output | 1 | Sticky interrupt flag (control bit 7) |

## Verification
Setting the flag on an overflow and clearing it can happen in the same clock cycle. A clear comes either from an acknowledge pulse or from a control write with bit 7 at zero. With 16 cycles per step and n = 0, overflows are exactly 32 cycles apart. The bench first synchronises to one `irq_o` pulse and clears the flag. It then times an acknowledge, and in a second run a flag-clearing write, to land on the edge of the next overflow. The check passes only if `irq_o` and `flag_o` are both 1 after that edge. Isolated clears, well away from any overflow, are checked separately to confirm that each clear works on its own.

// File: rtl/ivt_pkg.sv
// Package ivt_pkg
// Shared constants for the interval timer: control-register bit positions and
// the mapping from the prescaler select code to a divider width.
// Assumes an 8-bit register bus.
package ivt_pkg;

    localparam int REG_W    = 8;
    localparam int FLAG_BIT = 7;
    localparam int SRC_HI   = 6;
    localparam int SRC_LO   = 5;
    localparam int RSVD_BIT = 4;
    localparam int CLR_BIT  = 3;

    typedef enum logic [1:0] {
        SRC_DIV4096 = 2'b00,
        SRC_DIV1024 = 2'b01,
        SRC_DIV128  = 2'b10,
        SRC_DIV16   = 2'b11
    } src_sel_e;

    // Number of low prescaler bits that must all be 1 for a tick.
    function automatic int unsigned src_shift(input src_sel_e sel);
        case (sel)
            SRC_DIV4096: src_shift = 12;
            SRC_DIV1024: src_shift = 10;
            SRC_DIV128:  src_shift = 7;
            default:     src_shift = 4;
        endcase
    endfunction

endpackage

// File: rtl/ivt_prescaler.sv
// Module ivt_prescaler
// Free-running divider of the system clock. It produces a one-cycle tick once
// every 2^k cycles, where k comes from the select code.
// Assumes PRE_W is at least the largest divider width (12).
module ivt_prescaler
    import ivt_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic     clk,
    input  logic     rst_n,
    input  src_sel_e src_sel,
    output logic     tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] tap_mask;

    // Free-running divider count, wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Mask of the low bits that take part in the tick decode.
    always_comb begin
        tap_mask = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < int'(src_shift(src_sel))) tap_mask[i] = 1'b1;
        end
    end

    // Tick when all masked bits are 1, i.e. once per 2^k cycles.
    assign tick = &(pre_q | ~tap_mask);

endmodule

// File: rtl/ivt_counter.sv
// Module ivt_counter
// Up-counter that advances on prescaler ticks. It detects the 1-to-0 fall of
// the selected bit, and a synchronous clear takes priority over a tick.
// Assumes tick and clr_req are single-cycle pulses.
module ivt_counter #(
    parameter int CNT_W = 8,
    parameter int SEL_W = $clog2(CNT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr_req,
    input  logic [SEL_W-1:0] ovf_sel,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_evt
);

    logic [CNT_W-1:0] low_mask;
    logic             wrap_next;

    // Bits 0..n must all be 1 for bit n to fall on the next step.
    always_comb begin
        low_mask = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i <= int'(ovf_sel)) low_mask[i] = 1'b1;
        end
    end

    assign wrap_next = &(cnt_q | ~low_mask);

    // An overflow counts only when the counter actually steps.
    assign ovf_evt = tick & ~clr_req & wrap_next;

    // Counter state: clear wins over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clr_req) cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/ivt_ctrl.sv
// Module ivt_ctrl
// Control register fields, the self-clearing clear bit, the sticky flag and the
// registered interrupt request.
// Assumes ctl_we is one cycle per bus write and ovf_evt is single-cycle.
module ivt_ctrl
    import ivt_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [REG_W-1:0] wdata,
    input  logic             int_ack,
    input  logic             ovf_evt,
    output src_sel_e         src_sel,
    output logic [SEL_W-1:0] ovf_sel,
    output logic             clr_bit,
    output logic             clr_req,
    output logic             flag_q,
    output logic             irq_q
);

    logic flag_clear;

    assign clr_req    = ctl_we & wdata[CLR_BIT];
    assign flag_clear = int_ack | (ctl_we & ~wdata[FLAG_BIT]);

    // Writable selection fields; the reset default is n=1 and divide by 4096.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel <= SRC_DIV4096;
            ovf_sel <= SEL_W'(1);
        end else if (ctl_we) begin
            src_sel <= src_sel_e'(wdata[SRC_HI:SRC_LO]);
            ovf_sel <= wdata[SEL_W-1:0];
        end
    end

    // Clear bit holds the written 1 for one cycle, then drops by itself.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_bit <= 1'b0;
        else        clr_bit <= clr_req;
    end

    // Sticky flag: a set beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (ovf_evt)    flag_q <= 1'b1;
        else if (flag_clear) flag_q <= 1'b0;
    end

    // Interrupt request: one-cycle pulse aligned with the flag being set.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= ovf_evt;
    end

endmodule

// File: rtl/interval_tick_timer.sv
// Module interval_tick_timer
// Top level: register decode, read mux, prescaler, counter and control.
// Assumes single-cycle write strobes and a combinational read.
module interval_tick_timer
    import ivt_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          CNT_W    = 8,
    parameter int          PRE_W    = 12,
    parameter logic [7:0]  CTL_ADDR = 8'h8B,
    parameter logic [7:0]  CNT_ADDR = 8'h8C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              int_ack,
    output logic              irq_o,
    output logic              flag_o
);

    localparam int SEL_W = $clog2(CNT_W);

    logic             ctl_we;
    logic             tick;
    logic             clr_req;
    logic             clr_bit;
    logic             ovf_evt;
    src_sel_e         src_sel;
    logic [SEL_W-1:0] ovf_sel;
    logic [CNT_W-1:0] cnt_q;

    assign ctl_we = bus_we & (bus_addr == ADDR_W'(CTL_ADDR));

    ivt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sel (src_sel),
        .tick    (tick)
    );

    ivt_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clr_req (clr_req),
        .ovf_sel (ovf_sel),
        .cnt_q   (cnt_q),
        .ovf_evt (ovf_evt)
    );

    ivt_ctrl #(.SEL_W(SEL_W)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_we  (ctl_we),
        .wdata   (bus_wdata),
        .int_ack (int_ack),
        .ovf_evt (ovf_evt),
        .src_sel (src_sel),
        .ovf_sel (ovf_sel),
        .clr_bit (clr_bit),
        .clr_req (clr_req),
        .flag_q  (flag_o),
        .irq_q   (irq_o)
    );

    // Read mux: reserved bit 4 and unmapped addresses read as 0.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CNT_ADDR)) begin
            bus_rdata = REG_W'(cnt_q);
        end else if (bus_addr == ADDR_W'(CTL_ADDR)) begin
            bus_rdata[FLAG_BIT]      = flag_o;
            bus_rdata[SRC_HI:SRC_LO] = src_sel;
            bus_rdata[RSVD_BIT]      = 1'b0;
            bus_rdata[CLR_BIT]       = clr_bit;
            bus_rdata[SEL_W-1:0]     = ovf_sel;
        end
    end

endmodule

// File: rtl/ivt_checker.sv
// Module ivt_checker
// Temporal properties of the interval timer, bound into the top module.
// Assumes it observes the top-level ports plus the counter and clear bit.
module ivt_checker #(
    parameter logic [7:0] CTL_ADDR = 8'h8B
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bus_addr,
    input logic       bus_we,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       int_ack,
    input logic       irq_o,
    input logic       flag_o,
    input logic [7:0] cnt_q,
    input logic       clr_bit
);

    // R6: a clear write leaves the counter at zero after the edge.
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == CTL_ADDR && bus_wdata[3]) |=> (cnt_q == 8'h00));

    // R6: the clear bit never stays set for two cycles.
    a_r6_clr_self: assert property (@(posedge clk) disable iff (!rst_n)
        clr_bit |=> !clr_bit);

    // R7: the request is a single-cycle pulse.
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R7: every request comes with the flag set.
    a_r7_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);

    // R8: writing 1 to a clear flag does not set it.
    a_r8_write_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && bus_we && bus_addr == CTL_ADDR && bus_wdata[7]) |=> (!flag_o || irq_o));

    // R9: after an acknowledge the flag is clear unless a new event arrived.
    a_r9_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> (!flag_o || irq_o));

    // R11: the reserved control bit reads zero.
    a_r11_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == CTL_ADDR) |-> !bus_rdata[4]);

endmodule

bind interval_tick_timer ivt_checker #(.CTL_ADDR(CTL_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .int_ack   (int_ack),
    .irq_o     (irq_o),
    .flag_o    (flag_o),
    .cnt_q     (cnt_q),
    .clr_bit   (clr_bit)
);

// File: tb/interval_tick_timer_bench.sv
`timescale 1ns/1ps
module interval_tick_timer_bench;

    localparam logic [7:0] CTL = 8'h8B;
    localparam logic [7:0] CNT = 8'h8C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       int_ack = 1'b0;
    logic       irq_o;
    logic       flag_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    interval_tick_timer u_interval_tick_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .int_ack   (int_ack),
        .irq_o     (irq_o),
        .flag_o    (flag_o)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        step();
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_irq(input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit; i++) begin
            step();
            if (irq_o) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic measure(input logic [7:0] cfg, input int exp, input string req);
        bit seen;
        int n;
        bus_write(CTL, cfg);
        wait_irq(exp * 2 + 16, seen);
        n = 0;
        if (seen) begin
            do begin
                step();
                n++;
            end while (!irq_o && n <= exp + 4);
        end
        check(seen && n == exp, req, n, exp);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_read(CNT, d);
        check(d == 8'h00, "R1 counter", d, 8'h00);
        bus_read(CTL, d);
        check(d == 8'h01, "R1 control", d, 8'h01);
        check(irq_o == 1'b0 && flag_o == 1'b0, "R1 irq/flag", {irq_o, flag_o}, 0);
    endtask

    task automatic t_periods();
        measure(8'h01, 16384, "R4 default n=1 div4096");
        measure(8'h60, 32,    "R3 R4 div16 n=0");
        measure(8'h63, 256,   "R4 div16 n=3");
        measure(8'h67, 4096,  "R4 div16 n=7");
        measure(8'h41, 512,   "R3 div128 n=1");
        measure(8'h20, 2048,  "R3 div1024 n=0");
        measure(8'h00, 8192,  "R3 div4096 n=0");
    endtask

    task automatic t_counter();
        logic [7:0] d, v;
        bus_write(CTL, 8'h08);
        bus_read(CNT, d);
        check(d == 8'h00, "R6 clear to zero", d, 0);
        bus_write(CNT, 8'hFF);
        bus_read(CNT, d);
        check(d <= 8'h01, "R2 counter ignores write", d, 0);
        bus_read(8'h8A, d);
        check(d == 8'h00, "R2 unmapped reads zero", d, 0);
        bus_read(CNT, v);
        repeat (4096) step();
        bus_read(CNT, d);
        check(d == 8'(v + 1), "R5 one step per 4096", d, 8'(v + 1));
    endtask

    task automatic t_wrap();
        logic [7:0] d;
        bus_write(CTL, 8'h68);
        repeat (256 * 16) step();
        bus_read(CNT, d);
        check(d == 8'h00, "R5 wrap after 256 steps", d, 0);
    endtask

    task automatic t_clr_bit();
        logic [7:0] d;
        bus_write(CTL, 8'h68);
        bus_read(CTL, d);
        check(d[3] == 1'b1, "R6 clear bit reads 1", d[3], 1);
        bus_read(CNT, d);
        check(d == 8'h00, "R6 counter zero", d, 0);
        step();
        bus_read(CTL, d);
        check(d[3] == 1'b0, "R6 clear bit self-clears", d[3], 0);
        repeat (15) step();
        bus_read(CNT, d);
        check(d == 8'h01, "R6 counting resumes", d, 1);
    endtask

    task automatic t_flag();
        logic [7:0] d;
        bit seen;
        bus_write(CTL, 8'h60);
        wait_irq(80, seen);
        check(seen && flag_o, "R7 flag set with irq", {seen, flag_o}, 3);
        step();
        check(!irq_o && flag_o, "R7 irq one cycle, flag sticky", {irq_o, flag_o}, 1);
        bus_write(CTL, 8'h60);
        check(!flag_o, "R8 write zero clears", flag_o, 0);
        bus_write(CTL, 8'hE0);
        check(!flag_o, "R8 write one no effect", flag_o, 0);
        bus_write(CTL, 8'h70);
        bus_read(CTL, d);
        check(d == 8'h60, "R11 bit4 reads zero", d, 8'h60);
        wait_irq(80, seen);
        check(seen && flag_o, "R9 flag set before ack", flag_o, 1);
        int_ack = 1'b1;
        step();
        int_ack = 1'b0;
        check(!flag_o, "R9 ack clears", flag_o, 0);
    endtask

    task automatic t_collide(input bit use_write);
        bit seen;
        bus_write(CTL, 8'h60);
        wait_irq(80, seen);
        bus_write(CTL, 8'h60);
        repeat (30) step();
        check(seen && !flag_o, "R10 flag clear before collision", flag_o, 0);
        if (use_write) begin
            bus_write(CTL, 8'h60);
        end else begin
            int_ack = 1'b1;
            step();
            int_ack = 1'b0;
        end
        check(irq_o && flag_o, use_write ? "R10 set beats write-zero" : "R10 set beats ack",
              {irq_o, flag_o}, 3);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        t_reset();
        t_periods();
        t_counter();
        t_wrap();
        t_clr_bit();
        t_flag();
        t_collide(1'b0);
        t_collide(1'b1);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule